// File: doc/BRIEF.md
# Integer ALU with Barrel Shifter

This block is a purely combinational integer execute stage for a 32-bit datapath. Each cycle it takes two register operands, a 16-bit immediate, a shift-amount field and a four-bit operation code, and returns one result word. It covers addition and subtraction, the four bitwise operations, signed and unsigned less-than tests, placement of a constant in the upper half-word, and left, logical-right and arithmetic-right shifts.

Addition and subtraction come in two flavours. The trapping flavour raises an overflow flag when the two's-complement result does not fit. The wrapping flavour produces the same bits and never raises the flag. The result word is always driven. A separate write-enable qualifier drops whenever the flag is raised, so the register stage that follows can suppress the write and take the exception.

Operand B is either the second register or the immediate. The caller chooses whether the immediate is sign-extended (arithmetic and compares) or zero-extended (bitwise operations). The shift amount comes either from the constant field or from the low bits of the second register.

Top module: `int_exec_alu`

## Requirements
- R1: The operation code `op_sel` is decoded as: 0 add-trap, 1 add-wrap, 2 sub-trap, 3 sub-wrap, 4 AND, 5 OR, 6 XOR, 7 NOR, 8 signed less-than, 9 unsigned less-than, 10 upper-immediate, 11 shift left logical, 12 shift right logical, 13 shift right arithmetic.
- R2: For codes 0 and 2, `result` is A+B or A−B modulo 2^32, and `ovf_trap` is 1 exactly when the signed result overflows.
- R3: `ovf_trap` is 0 for every code other than 0 and 2. Codes 1 and 3 give the same `result` bits as codes 0 and 2.
- R4: `wr_ok` is the inverse of `ovf_trap`, and `result` still carries the wrapped sum or difference when the flag is set.
- R5: Codes 4 to 7 return A&B, A|B, A^B and ~(A|B), computed bitwise.
- R6: Code 8 returns 1 when A < B in two's complement, and 0 otherwise. All upper bits are 0.
- R7: Code 9 returns 1 when A < B as unsigned numbers, and 0 otherwise. All upper bits are 0.
- R8: When `b_is_imm` is 1, operand B is the 16-bit `imm_val` extended to 32 bits. The extension copies bit 15 when `imm_signed` is 1 and fills with zeros when it is 0. When `b_is_imm` is 0, operand B is `src_b`.
- R9: Code 10 returns `imm_val` in bits 31:16 and zeros in bits 15:0. An OR with a zero-extended immediate then fills the low half.
- R10: Codes 11 and 12 shift A left or right by the amount and fill the vacated bits with 0.
- R11: Code 13 shifts A right and fills the vacated bits with copies of A[31]. No code performs an arithmetic left shift.
- R12: With `amt_from_reg` at 0 the shift amount is `shamt`. With it at 1 the amount is `src_b[4:0]`, and the higher bits of `src_b` have no effect.
- R13: Codes 14 and 15 return 0 with `ovf_trap` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code |
| src_a | input | 32 | First operand, also the value that is shifted |
| src_b | input | 32 | Second register operand, also the variable shift amount |
| imm_val | input | 16 | Immediate constant |
| b_is_imm | input | 1 | Use the extended immediate as operand B |
| imm_signed | input | 1 | 1 sign-extends the immediate, 0 zero-extends it |
| shamt | input | 5 | Constant shift amount |
| amt_from_reg | input | 1 | Take the shift amount from src_b |
| result | output | 32 | Result word |
| ovf_trap | output | 1 | Signed overflow on a trapping add or subtract |
| wr_ok | output | 1 | Result may be written back |

## Verification
The bench builds the block at its default widths of 32 bits of data and 16 bits of immediate. It builds two copies: one with the logarithmic-stage shifter and one with the behavioural shifter, and checks both against the same expected values. This brings both generate branches into the run. At 32 bits the overflow boundaries (0x7FFFFFFF+1, 0x80000000−1), every shift distance from 0 to 31, and register shift amounts with junk in the upper bits are all reachable by directed vectors. Random vectors over all sixteen codes and both immediate extensions cover the rest.

// File: rtl/int_exec_alu_pkg.sv
package int_exec_alu_pkg;
   typedef enum logic [3:0] {
      OP_ADD  = 4'd0,
      OP_ADDW = 4'd1,
      OP_SUB  = 4'd2,
      OP_SUBW = 4'd3,
      OP_AND  = 4'd4,
      OP_OR   = 4'd5,
      OP_XOR  = 4'd6,
      OP_NOR  = 4'd7,
      OP_SLT  = 4'd8,
      OP_SLTU = 4'd9,
      OP_UPI  = 4'd10,
      OP_SLL  = 4'd11,
      OP_SRL  = 4'd12,
      OP_SRA  = 4'd13
   } alu_op_e;

   typedef enum logic [1:0] {
      SH_LEFT  = 2'd0,
      SH_RLOG  = 2'd1,
      SH_RARI  = 2'd2
   } shift_kind_e;

   typedef enum logic [1:0] {
      LG_AND = 2'd0,
      LG_OR  = 2'd1,
      LG_XOR = 2'd2,
      LG_NOR = 2'd3
   } logic_fn_e;
endpackage

// File: rtl/int_exec_addsub.sv
module int_exec_addsub #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic             subtract,
   output logic [WIDTH-1:0] sum,
   output logic             sgn_ovf,
   output logic             lt_signed,
   output logic             lt_unsigned
);
   localparam int MSB = WIDTH - 1;

   logic [WIDTH-1:0] b_eff;
   logic [WIDTH:0]   wide;

   always_comb begin
      b_eff       = subtract ? ~opb : opb;
      wide        = {1'b0, opa} + {1'b0, b_eff} + {{WIDTH{1'b0}}, subtract};
      sum         = wide[MSB:0];
      sgn_ovf     = (opa[MSB] == b_eff[MSB]) && (sum[MSB] != opa[MSB]);
      lt_unsigned = ~wide[WIDTH];
      lt_signed   = (opa[MSB] != opb[MSB]) ? opa[MSB] : sum[MSB];
   end
endmodule

// File: rtl/int_exec_logic.sv
module int_exec_logic
   import int_exec_alu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic_fn_e        fn,
   output logic [WIDTH-1:0] y
);
   always_comb begin
      unique case (fn)
         LG_AND:  y = opa & opb;
         LG_OR:   y = opa | opb;
         LG_XOR:  y = opa ^ opb;
         default: y = ~(opa | opb);
      endcase
   end
endmodule

// File: rtl/int_exec_shifter.sv
module int_exec_shifter
   import int_exec_alu_pkg::*;
#(
   parameter int WIDTH  = 32,
   parameter bit BARREL = 1'b1,
   localparam int SHW   = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] val,
   input  logic [SHW-1:0]   amt,
   input  shift_kind_e      kind,
   output logic [WIDTH-1:0] y
);
   if (BARREL) begin : g_stages
      logic [WIDTH-1:0] stg [SHW+1];
      logic [WIDTH-1:0] rev_in;
      logic [WIDTH-1:0] rev_out;
      logic             fill;

      always_comb begin
         for (int i = 0; i < WIDTH; i++) rev_in[i] = val[WIDTH-1-i];
         fill = (kind == SH_RARI) & val[WIDTH-1];
      end

      assign stg[0] = (kind == SH_LEFT) ? rev_in : val;

      for (genvar s = 0; s < SHW; s++) begin : g_lvl
         localparam int D = 1 << s;
         assign stg[s+1] = amt[s] ? {{D{fill}}, stg[s][WIDTH-1:D]} : stg[s];
      end

      always_comb begin
         for (int i = 0; i < WIDTH; i++) rev_out[i] = stg[SHW][WIDTH-1-i];
         y = (kind == SH_LEFT) ? rev_out : stg[SHW];
      end
   end else begin : g_flat
      always_comb begin
         unique case (kind)
            SH_LEFT: y = val << amt;
            SH_RLOG: y = val >> amt;
            default: y = $unsigned($signed(val) >>> amt);
         endcase
      end
   end
endmodule

// File: rtl/int_exec_alu.sv
module int_exec_alu
   import int_exec_alu_pkg::*;
#(
   parameter int WIDTH  = 32,
   parameter int IMM_W  = 16,
   parameter bit BARREL = 1'b1,
   localparam int SHW   = $clog2(WIDTH)
) (
   input  logic [3:0]       op_sel,
   input  logic [WIDTH-1:0] src_a,
   input  logic [WIDTH-1:0] src_b,
   input  logic [IMM_W-1:0] imm_val,
   input  logic             b_is_imm,
   input  logic             imm_signed,
   input  logic [SHW-1:0]   shamt,
   input  logic             amt_from_reg,
   output logic [WIDTH-1:0] result,
   output logic             ovf_trap,
   output logic             wr_ok
);
   localparam int LOW_W = WIDTH - IMM_W;

   if ((1 << SHW) != WIDTH) begin : g_chk_pow2
      $error("WIDTH must be a power of two");
   end
   if (IMM_W < 1 || IMM_W >= WIDTH) begin : g_chk_imm
      $error("IMM_W must be between 1 and WIDTH-1");
   end

   logic [WIDTH-1:0] imm_ext;
   logic [WIDTH-1:0] opb;
   logic [WIDTH-1:0] as_sum, lg_y, sh_y;
   logic             as_ovf, as_lts, as_ltu, as_sub;
   logic [SHW-1:0]   sh_amt;
   logic_fn_e        lg_fn;
   shift_kind_e      sh_kind;

   always_comb begin
      imm_ext = {{LOW_W{imm_signed & imm_val[IMM_W-1]}}, imm_val};
      opb     = b_is_imm ? imm_ext : src_b;
      as_sub  = (op_sel != OP_ADD) && (op_sel != OP_ADDW);
      lg_fn   = logic_fn_e'(op_sel[1:0]);
      sh_amt  = amt_from_reg ? src_b[SHW-1:0] : shamt;
      unique case (op_sel)
         OP_SRL:  sh_kind = SH_RLOG;
         OP_SRA:  sh_kind = SH_RARI;
         default: sh_kind = SH_LEFT;
      endcase
   end

   int_exec_addsub #(.WIDTH(WIDTH)) u_addsub (
      .opa(src_a), .opb(opb), .subtract(as_sub),
      .sum(as_sum), .sgn_ovf(as_ovf),
      .lt_signed(as_lts), .lt_unsigned(as_ltu)
   );

   int_exec_logic #(.WIDTH(WIDTH)) u_logic (
      .opa(src_a), .opb(opb), .fn(lg_fn), .y(lg_y)
   );

   int_exec_shifter #(.WIDTH(WIDTH), .BARREL(BARREL)) u_shift (
      .val(src_a), .amt(sh_amt), .kind(sh_kind), .y(sh_y)
   );

   always_comb begin
      result   = '0;
      ovf_trap = 1'b0;
      unique case (op_sel)
         OP_ADD, OP_SUB: begin
            result   = as_sum;
            ovf_trap = as_ovf;
         end
         OP_ADDW, OP_SUBW:               result = as_sum;
         OP_AND, OP_OR, OP_XOR, OP_NOR:  result = lg_y;
         OP_SLT:                         result = {{(WIDTH-1){1'b0}}, as_lts};
         OP_SLTU:                        result = {{(WIDTH-1){1'b0}}, as_ltu};
         OP_UPI:                         result = {imm_val, {LOW_W{1'b0}}};
         OP_SLL, OP_SRL, OP_SRA:         result = sh_y;
         default:                        result = '0;
      endcase
      wr_ok = ~ovf_trap;
   end
endmodule

// File: rtl/int_exec_alu_checker.sv
module int_exec_alu_checker #(
   parameter int WIDTH = 32,
   parameter int IMM_W = 16,
   localparam int SHW  = $clog2(WIDTH)
) (
   input logic [3:0]       op_sel,
   input logic [WIDTH-1:0] src_a,
   input logic [WIDTH-1:0] src_b,
   input logic [SHW-1:0]   shamt,
   input logic             amt_from_reg,
   input logic [WIDTH-1:0] result,
   input logic             ovf_trap,
   input logic             wr_ok
);
   logic [SHW-1:0] amt;

   always_comb begin
      amt = amt_from_reg ? src_b[SHW-1:0] : shamt;
      // R3: only the two trapping codes may raise the flag
      a_r3_no_overflow: assert (ovf_trap == 1'b0 || op_sel == 4'd0 || op_sel == 4'd2)
         else $error("overflow flag on a non-trapping code %0d", op_sel);
      // R4: a trapped result is never released for writeback
      a_r4_wr_blocked: assert (!(ovf_trap && wr_ok))
         else $error("write enabled while overflow flag set");
      // R6 / R7: compare results are a single bit
      a_r6_cmp_bool: assert (!(op_sel == 4'd8 || op_sel == 4'd9) || result[WIDTH-1:1] == '0)
         else $error("compare result wider than one bit");
      // R9: upper-immediate leaves the low half clear
      a_r9_upi_low: assert (op_sel != 4'd10 || result[WIDTH-IMM_W-1:0] == '0)
         else $error("upper-immediate low half not zero");
      // R10: logical right shift by a nonzero amount clears the top bit
      a_r10_srl_fill: assert (op_sel != 4'd12 || amt == '0 || result[WIDTH-1] == 1'b0)
         else $error("logical right shift filled with one");
      // R11: arithmetic right shift keeps the sign bit
      a_r11_sra_sign: assert (op_sel != 4'd13 || result[WIDTH-1] == src_a[WIDTH-1])
         else $error("arithmetic right shift lost the sign");
      // R13: unused codes give zero
      a_r13_unused: assert (op_sel < 4'd14 || result == '0)
         else $error("unused code gave nonzero result");
   end
endmodule

bind int_exec_alu int_exec_alu_checker #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_chk (
   .op_sel(op_sel), .src_a(src_a), .src_b(src_b), .shamt(shamt),
   .amt_from_reg(amt_from_reg), .result(result), .ovf_trap(ovf_trap), .wr_ok(wr_ok)
);

// File: tb/int_exec_alu_test.sv
module int_exec_alu_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [3:0]  op_sel = '0;
   logic [31:0] src_a = '0, src_b = '0;
   logic [15:0] imm_val = '0;
   logic        b_is_imm = 1'b0, imm_signed = 1'b0, amt_from_reg = 1'b0;
   logic [4:0]  shamt = '0;
   logic [31:0] res0, res1;
   logic        ovf0, ovf1, wok0, wok1;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #4 clk = ~clk;

   int_exec_alu #(.BARREL(1'b1)) uut (
      .op_sel(op_sel), .src_a(src_a), .src_b(src_b), .imm_val(imm_val),
      .b_is_imm(b_is_imm), .imm_signed(imm_signed), .shamt(shamt),
      .amt_from_reg(amt_from_reg), .result(res0), .ovf_trap(ovf0), .wr_ok(wok0)
   );

   int_exec_alu #(.BARREL(1'b0)) uut_alt (
      .op_sel(op_sel), .src_a(src_a), .src_b(src_b), .imm_val(imm_val),
      .b_is_imm(b_is_imm), .imm_signed(imm_signed), .shamt(shamt),
      .amt_from_reg(amt_from_reg), .result(res1), .ovf_trap(ovf1), .wr_ok(wok1)
   );

   function automatic string tag_of(input logic [3:0] op);
      case (op)
         4'd0, 4'd2:             return "R1 R2";
         4'd1, 4'd3:             return "R1 R3";
         4'd4, 4'd5, 4'd6, 4'd7: return "R1 R5";
         4'd8:                   return "R1 R6";
         4'd9:                   return "R1 R7";
         4'd10:                  return "R1 R9";
         4'd11, 4'd12:           return "R1 R10";
         4'd13:                  return "R1 R11";
         default:                return "R13";
      endcase
   endfunction

   // expected {ovf, result} computed from the requirements
   function automatic logic [32:0] model(input logic [3:0] op, input logic [31:0] a,
                                         input logic [31:0] rb, input logic [15:0] imm,
                                         input bit isel, input bit isgn,
                                         input logic [4:0] sh, input bit av);
      logic [31:0] b;
      longint      sa, sb, wide;
      int          n;
      logic [31:0] r;
      bit          ov;
      b  = isel ? (isgn ? {{16{imm[15]}}, imm} : {16'h0, imm}) : rb;
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      n  = av ? int'(rb[4:0]) : int'(sh);
      ov = 1'b0;
      r  = '0;
      case (op)
         4'd0, 4'd1: begin wide = sa + sb; r = a + b; ov = (op == 4'd0) && (wide > 64'sd2147483647 || wide < -64'sd2147483648); end
         4'd2, 4'd3: begin wide = sa - sb; r = a - b; ov = (op == 4'd2) && (wide > 64'sd2147483647 || wide < -64'sd2147483648); end
         4'd4:  r = a & b;
         4'd5:  r = a | b;
         4'd6:  r = a ^ b;
         4'd7:  r = ~(a | b);
         4'd8:  r = (sa < sb) ? 32'd1 : 32'd0;
         4'd9:  r = (a < b) ? 32'd1 : 32'd0;
         4'd10: r = {imm, 16'h0};
         4'd11: r = a << n;
         4'd12: r = a >> n;
         4'd13: r = $unsigned($signed(a) >>> n);
         default: r = '0;
      endcase
      return {ov, r};
   endfunction

   task automatic one_check(input bit ok, input string tag, input string what,
                            input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
      end
   endtask

   task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                        input logic [15:0] imm, input bit isel, input bit isgn,
                        input logic [4:0] sh, input bit av, input string extra);
      logic [32:0] e;
      string t;
      @(negedge clk);
      op_sel = op; src_a = a; src_b = b; imm_val = imm;
      b_is_imm = isel; imm_signed = isgn; shamt = sh; amt_from_reg = av;
      #1;
      e = model(op, a, b, imm, isel, isgn, sh, av);
      t = (extra == "") ? tag_of(op) : {tag_of(op), " ", extra};
      one_check(res0 == e[31:0], t, "result", res0, e[31:0]);
      one_check(ovf0 == e[32], t, "ovf_trap", {31'h0, ovf0}, {31'h0, e[32]});
      one_check(wok0 == ~e[32], {t, " R4"}, "wr_ok", {31'h0, wok0}, {31'h0, ~e[32]});
      one_check(res1 == e[31:0], {t, " alt"}, "result", res1, e[31:0]);
      one_check(ovf1 == e[32], {t, " alt"}, "ovf_trap", {31'h0, ovf1}, {31'h0, e[32]});
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      logic [31:0] ra, rb;
      void'($urandom(32'd20240517));
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // reset state: all inputs zero -> add of zeros
      apply(4'd0, 32'h0, 32'h0, 16'h0, 0, 0, 5'd0, 0, "reset");
      // R2 overflow corners
      apply(4'd0, 32'h7FFFFFFF, 32'h1, 16'h0, 0, 0, 0, 0, "max+1");
      apply(4'd0, 32'h80000000, 32'h80000000, 16'h0, 0, 0, 0, 0, "min+min");
      apply(4'd2, 32'h80000000, 32'h1, 16'h0, 0, 0, 0, 0, "min-1");
      apply(4'd2, 32'h0, 32'h80000000, 16'h0, 0, 0, 0, 0, "0-min");
      apply(4'd2, 32'hFFFFFFFF, 32'h80000000, 16'h0, 0, 0, 0, 0, "-1-min");
      // R3 wrapping forms on the same corners
      apply(4'd1, 32'h7FFFFFFF, 32'h1, 16'h0, 0, 0, 0, 0, "");
      apply(4'd3, 32'h80000000, 32'h1, 16'h0, 0, 0, 0, 0, "");
      // R8 immediate extension
      apply(4'd0, 32'h7FFFFFF0, 32'h0, 16'h0020, 1, 1, 0, 0, "R8 addimm ovf");
      apply(4'd0, 32'h10, 32'hDEAD, 16'hFFFF, 1, 1, 0, 0, "R8 sext");
      apply(4'd5, 32'h10, 32'hDEAD, 16'hFFFF, 1, 0, 0, 0, "R8 zext");
      apply(4'd8, 32'h5, 32'h0, 16'hFFF0, 1, 1, 0, 0, "R8 slt imm");
      // R6 / R7 compare corners
      apply(4'd8, 32'h80000000, 32'h7FFFFFFF, 16'h0, 0, 0, 0, 0, "");
      apply(4'd9, 32'h80000000, 32'h7FFFFFFF, 16'h0, 0, 0, 0, 0, "");
      apply(4'd8, 32'h1234, 32'h1234, 16'h0, 0, 0, 0, 0, "equal");
      apply(4'd9, 32'h0, 32'hFFFFFFFF, 16'h0, 0, 0, 0, 0, "");
      // R9 upper immediate then OR of low half
      apply(4'd10, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'hAAAA, 0, 0, 0, 0, "");
      apply(4'd5, 32'hAAAA0000, 32'h0, 16'h5555, 1, 0, 0, 0, "R9 low fill");
      // R5 NOR
      apply(4'd7, 32'hF0F00000, 32'h00F0000F, 16'h0, 0, 0, 0, 0, "");
      // R10 / R11 / R12 shifts
      for (int s = 0; s < 32; s++) begin
         apply(4'd11, 32'h80000001, 32'h0, 16'h0, 0, 0, s[4:0], 0, "R12 const");
         apply(4'd12, 32'h80000001, 32'h0, 16'h0, 0, 0, s[4:0], 0, "R12 const");
         apply(4'd13, 32'h80000001, 32'h0, 16'h0, 0, 0, s[4:0], 0, "R12 const");
      end
      apply(4'd12, 32'hF000000F, 32'hFFFFFFE4, 16'h0, 0, 0, 5'd1, 1, "R12 reg upper junk");
      apply(4'd13, 32'hF000000F, 32'h12345663, 16'h0, 0, 0, 5'd7, 1, "R12 reg");
      apply(4'd11, 32'h0000FFFF, 32'hFFFFFFF0, 16'h0, 0, 0, 5'd3, 1, "R12 reg");
      // R13 unused codes
      apply(4'd14, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'hFFFF, 0, 0, 0, 0, "");
      apply(4'd15, 32'h7FFFFFFF, 32'h7FFFFFFF, 16'hFFFF, 1, 1, 5'd31, 1, "");
      // random mix
      for (int i = 0; i < 3000; i++) begin
         ra = $urandom;
         rb = $urandom;
         case ($urandom % 4)
            0: ra = {ra[31], {31{ra[31]}} ^ 31'h7FFFFFFF} ^ {31'h0, ra[0]};
            1: rb = {rb[31], {31{~rb[31]}}};
            default: ;
         endcase
         apply(4'($urandom % 16), ra, rb, 16'($urandom), 1'($urandom), 1'($urandom),
               5'($urandom), 1'($urandom), "rand");
      end
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule